// File: doc/BRIEF.md
# Cascadable Delayed Parity Checker

This block checks parity on a registered command/address word whose parity bit comes in later than the word itself. Each sampled word is reduced to one parity bit. That bit travels down a short lag line until the matching parity input arrives. The checker then combines the two and drives two registered results. The first is a partial-parity bit that can feed the parity input of a second checker. The second is an active-low error flag, and it is stretched so that it stays asserted for a minimum number of cycles.

A static mode input sets the position of the checker in a system. With mode low, the checker works alone or as the first of a chained pair, and the parity bit arrives one cycle after its word. With mode high, the checker is the second of a pair, and its parity input is the first checker's partial-parity output, which arrives two cycles after the word. When both active-low select inputs were high for a word, that word is treated as idle and both outputs hold their state. A synchronous active-high reset clears everything and takes priority over select gating.

Top module: `pcb_parity_chk`

## Requirements
- R1: The partial-parity output equals the XOR of every bit of the data word XOR the parity input that belongs to that word. A value of 0 means the word and its parity bit agree (even parity).
- R2: With `mode_back` low, the parity bit for the word sampled at clock edge t is sampled at edge t+1. Both outputs take the result at edge t+1, which is the second cycle after the word was presented.
- R3: With `mode_back` high, the parity bit for the word sampled at edge t is sampled at edge t+2. Both outputs take the result at edge t+2, which is the third cycle after the word was presented.
- R4: `err_n` goes low at the same edge that loads a partial-parity value of 1.
- R5: After an error, `err_n` stays low for HOLD_CYC output updates (default 2) and then returns high if no further error is found.
- R6: An error found while `err_n` is already held low restarts the full HOLD_CYC window.
- R7: When `sel_a_n` and `sel_b_n` were both high at the edge that sampled a word, the edge that would have output that word's result leaves `ppo`, `err_n` and the remaining hold count unchanged.
- R8: When at least one select is low, the word is checked normally. The select levels never enter the parity value.
- R9: While `rst` is high at a clock edge, that edge drives `ppo` to 0 and `err_n` to 1, clears the hold window and the lag line, and overrides select gating.
- R10: A checker in mode high whose `par_in` is driven from the `ppo` of a checker in mode low flags an error exactly when the parity of both data words XOR the first checker's parity input is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_back | input | 1 | 0: single or first of a pair (lag 1); 1: second of a pair (lag 2) |
| sel_a_n | input | 1 | First select, active low |
| sel_b_n | input | 1 | Second select, active low |
| data_in | input | DATA_W | Data bits that take part in parity |
| par_in | input | 1 | Parity bit, arriving late relative to its word |
| ppo | output | 1 | Registered partial-parity result |
| err_n | output | 1 | Registered parity error flag, active low, stretched |

## Verification
The bench builds two instances. The first uses the defaults (14 data bits, a two-cycle hold) and runs in both modes. The second is fixed in mode high, with 6 data bits and a three-cycle hold, and its parity input is wired to the first instance's `ppo`. Together they cover both lag depths and a hold window longer than the latency. When the first instance is in mode low, the pair also exercises the chained partial-parity path. Random words, injected parity flips and select gating are chosen so that back-to-back errors, frozen outputs inside a hold window, and a reset in the middle of a hold all occur.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  // One entry of the lag line: parity of a sampled word plus its idle mark.
  typedef struct packed {
    logic par;
    logic idle;
  } pcb_tap_t;

  localparam pcb_tap_t PCB_TAP_CLR = '{par: 1'b0, idle: 1'b0};

endpackage

// File: rtl/pcb_word_fold.sv
module pcb_word_fold
  import pcb_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic              sel_a_n_i,
  input  logic              sel_b_n_i,
  output pcb_tap_t          tap_o
);

  // Reduce the word to a single parity bit; selects only mark idle words.
  always_comb begin
    tap_o.par  = ^word_i;
    tap_o.idle = sel_a_n_i & sel_b_n_i;
  end

endmodule

// File: rtl/pcb_lag_line.sv
module pcb_lag_line
  import pcb_pkg::*;
#(
  parameter int BASE_LAG = 1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     extra_lag_i,
  input  pcb_tap_t tap_i,
  output pcb_tap_t tap_o
);

  localparam int DEPTH = BASE_LAG + 1;

  pcb_tap_t stage_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= PCB_TAP_CLR;
    else     stage_q[0] <= tap_i;
  end

  generate
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= PCB_TAP_CLR;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  endgenerate

  // Tap point picks how long a word waits for its parity bit.
  assign tap_o = extra_lag_i ? stage_q[DEPTH-1] : stage_q[BASE_LAG-1];

endmodule

// File: rtl/pcb_err_stretch.sv
module pcb_err_stretch #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  input  logic freeze_i,
  output logic err_n_o
);

  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYC - 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_n_o <= 1'b1;
      left_q  <= '0;
    end else if (!freeze_i) begin
      if (fire_i) begin
        err_n_o <= 1'b0;
        left_q  <= RELOAD;
      end else if (left_q != '0) begin
        left_q  <= left_q - 1'b1;
      end else begin
        err_n_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcb_parity_chk.sv
module pcb_parity_chk
  import pcb_pkg::*;
#(
  parameter int DATA_W   = 14,
  parameter int HOLD_CYC = 2,
  parameter int BASE_LAG = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_back,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic [DATA_W-1:0] data_in,
  input  logic              par_in,
  output logic              ppo,
  output logic              err_n
);

  pcb_tap_t word_tap;
  pcb_tap_t late_tap;
  logic     mismatch;

  pcb_word_fold #(.DATA_W(DATA_W)) u_fold (
    .word_i    (data_in),
    .sel_a_n_i (sel_a_n),
    .sel_b_n_i (sel_b_n),
    .tap_o     (word_tap)
  );

  pcb_lag_line #(.BASE_LAG(BASE_LAG)) u_lag (
    .clk         (clk),
    .rst         (rst),
    .extra_lag_i (mode_back),
    .tap_i       (word_tap),
    .tap_o       (late_tap)
  );

  assign mismatch = late_tap.par ^ par_in;

  always_ff @(posedge clk) begin
    if (rst)                ppo <= 1'b0;
    else if (!late_tap.idle) ppo <= mismatch;
  end

  pcb_err_stretch #(.HOLD_CYC(HOLD_CYC)) u_stretch (
    .clk      (clk),
    .rst      (rst),
    .fire_i   (mismatch),
    .freeze_i (late_tap.idle),
    .err_n_o  (err_n)
  );

endmodule

// File: rtl/pcb_parity_chk_sva.sv
module pcb_parity_chk_sva (
  input logic clk,
  input logic rst,
  input logic mode_back,
  input logic sel_a_n,
  input logic sel_b_n,
  input logic ppo,
  input logic err_n
);

  AST_RST_FORCES: assert property (@(posedge clk)
    rst |=> (!ppo && err_n)); // R9

  AST_ERR_WITH_PPO: assert property (@(posedge clk) disable iff (rst)
    $fell(err_n) |-> ppo); // R4

  AST_ERR_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    ($fell(err_n) && !rst) |=> !err_n); // R5

  AST_IDLE_HOLD_LAG1: assert property (@(posedge clk) disable iff (rst)
    (!mode_back && $past(!mode_back) && $past(sel_a_n && sel_b_n) && !$past(rst))
      |=> ($stable(ppo) && $stable(err_n))); // R7

  AST_IDLE_HOLD_LAG2: assert property (@(posedge clk) disable iff (rst)
    (mode_back && $past(mode_back) && $past(mode_back, 2) &&
     $past(sel_a_n && sel_b_n, 2) && !$past(rst) && !$past(rst, 2))
      |=> ($stable(ppo) && $stable(err_n))); // R3

endmodule

bind pcb_parity_chk pcb_parity_chk_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .mode_back (mode_back),
  .sel_a_n   (sel_a_n),
  .sel_b_n   (sel_b_n),
  .ppo       (ppo),
  .err_n     (err_n)
);

// File: tb/pcb_parity_chk_tb.sv
module pcb_parity_chk_tb;

  localparam int W0 = 14;
  localparam int H0 = 2;
  localparam int W1 = 6;
  localparam int H1 = 3;
  localparam int N  = 4096;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          mode0 = 1'b0;
  logic          sa = 1'b0, sb = 1'b0;
  logic [W0-1:0] d0 = '0;
  logic [W1-1:0] d1 = '0;
  logic          pa0 = 1'b0;
  logic          ppo0, errn0, ppo1, errn1;

  pcb_parity_chk #(.DATA_W(W0), .HOLD_CYC(H0)) u_dut (
    .clk(clk), .rst(rst), .mode_back(mode0), .sel_a_n(sa), .sel_b_n(sb),
    .data_in(d0), .par_in(pa0), .ppo(ppo0), .err_n(errn0)
  );

  pcb_parity_chk #(.DATA_W(W1), .HOLD_CYC(H1)) u_back (
    .clk(clk), .rst(rst), .mode_back(1'b1), .sel_a_n(sa), .sel_b_n(sb),
    .data_in(d1), .par_in(ppo0), .ppo(ppo1), .err_n(errn1)
  );

  // Reference history and expected outputs
  logic [W0-1:0] hd0 [N];
  logic [W1-1:0] hd1 [N];
  bit            hidle [N];
  int  n = 0;
  int  last_rst = -1;
  bit  e_ppo0 = 0, e_err0 = 1, e_ppo1 = 0, e_err1 = 1;
  int  left0 = 0, left1 = 0;
  int  checks = 0, errors = 0;
  string phase = "R9";
  bit  done = 0;

  always @(posedge clk) begin
    int  i0, i1;
    bit  wp, wi, x, front_prev;
    if (n < N) begin
      hd0[n] = d0; hd1[n] = d1; hidle[n] = sa & sb;
      front_prev = e_ppo0;
      i0 = n - (mode0 ? 2 : 1);
      if (i0 >= 0 && i0 > last_rst) begin wp = ^hd0[i0]; wi = hidle[i0]; end
      else begin wp = 0; wi = 0; end
      x = wp ^ pa0;
      if (rst) begin e_ppo0 = 0; e_err0 = 1; left0 = 0; end
      else if (!wi) begin
        e_ppo0 = x;
        if (x) left0 = H0; else if (left0 > 0) left0--;
        e_err0 = (left0 == 0);
      end
      i1 = n - 2;
      if (i1 >= 0 && i1 > last_rst) begin wp = ^hd1[i1]; wi = hidle[i1]; end
      else begin wp = 0; wi = 0; end
      x = wp ^ front_prev;
      if (rst) begin e_ppo1 = 0; e_err1 = 1; left1 = 0; end
      else if (!wi) begin
        e_ppo1 = x;
        if (x) left1 = H1; else if (left1 > 0) left1--;
        e_err1 = (left1 == 0);
      end
      if (rst) last_rst = n;
      n++;
    end
  end

  task automatic chk(string tag, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %b expected %b", tag, n, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (n > 0 && !done) begin
      chk({phase, " front ppo (R1)"}, ppo0, e_ppo0);
      chk({phase, " front err_n (R4)"}, errn0, e_err0);
      chk({phase, " back ppo (R10)"}, ppo1, e_ppo1);
      chk({phase, " back err_n (R10)"}, errn1, e_err1);
    end
  end

  // Drive one cycle; parity is correct for both words of lag cycles ago unless flipped.
  task automatic step(bit r, bit flip, bit a, bit b, logic [W0-1:0] x0, logic [W1-1:0] x1);
    int lag;
    @(negedge clk);
    lag = mode0 ? 2 : 1;
    rst = r; sa = a; sb = b; d0 = x0; d1 = x1;
    if (n >= lag) pa0 = (^hd0[n-lag]) ^ (^hd1[n-lag]) ^ flip;
    else          pa0 = flip;
  endtask

  task automatic clean(int k);
    for (int i = 0; i < k; i++) step(0, 0, 0, 0, W0'($urandom), W1'(0));
  endtask

  task automatic rand_run(int k, bit casc);
    for (int i = 0; i < k; i++)
      step(0, ($urandom % 6) == 0, ($urandom % 3) == 0, ($urandom % 2) == 0,
           W0'($urandom), casc ? W1'($urandom) : W1'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    phase = "R9 reset";
    chk("R9 reset ppo", ppo0, 1'b0);
    chk("R9 reset err_n", errn0, 1'b1);

    phase = "R1 R2 R8 clean";
    clean(12);
    phase = "R2 R4 R5 single";
    step(0, 1, 0, 0, W0'($urandom), '0);
    clean(6);
    phase = "R6 restart";
    step(0, 1, 0, 0, W0'($urandom), '0);
    clean(1);
    step(0, 1, 0, 0, W0'($urandom), '0);
    clean(6);
    phase = "R7 idle word";
    step(0, 0, 1, 1, W0'($urandom), '0);
    step(0, 1, 0, 0, W0'($urandom), '0);
    clean(4);
    step(0, 1, 0, 0, W0'($urandom), '0);
    step(0, 0, 1, 1, W0'($urandom), '0);
    step(0, 0, 1, 1, W0'($urandom), '0);
    clean(6);
    phase = "R8 one select";
    step(0, 0, 1, 0, W0'($urandom), '0);
    step(0, 1, 0, 1, W0'($urandom), '0);
    clean(5);
    phase = "R9 mid hold";
    step(0, 1, 0, 0, W0'($urandom), '0);
    step(1, 0, 1, 1, W0'($urandom), '0);
    step(0, 1, 0, 0, W0'($urandom), '0);
    clean(5);
    phase = "R10 cascade";
    rand_run(120, 1);
    clean(6);

    phase = "R3 lag two";
    step(1, 0, 0, 0, '0, '0);
    mode0 = 1'b1;
    step(1, 0, 0, 0, '0, '0);
    clean(6);
    step(0, 1, 0, 0, W0'($urandom), '0);
    clean(6);
    step(0, 0, 1, 1, W0'($urandom), '0);
    step(0, 0, 0, 0, W0'($urandom), '0);
    step(0, 1, 0, 0, W0'($urandom), '0);
    clean(6);
    phase = "R3 R6 R7 random";
    rand_run(150, 0);
    clean(6);

    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule